// File: doc/BRIEF.md
# Dual-role SPI port controller

This block is one serial peripheral interface port that can act as the bus master or as a selected slave. The choice is made by a bit in its control register. As master it accepts a parallel word, produces a gated serial clock from a programmable divider of the system clock, and shifts the word out on master-out while it samples master-in. As slave it follows an external serial clock, but only while its active-low select input is low. It shifts its own word out on master-in and assembles the word arriving on master-out.

Software sets the control register through a simple write port and reads back status. Transmit words enter through a valid/ready handshake. Each completed word is presented with a one-cycle receive strobe and also sets a sticky status bit. The select line is also watched in master mode. If another device pulls it low, the controller stops the transfer at once, releases every pin it drives, leaves master mode and records a sticky fault. For broadcast reception the slave output can be disabled, and it can also be made open-drain.

Top module: `spi_dual_port`

## Requirements
- R1: In master mode the serial clock rests at the CPOL level (control bit 2) and toggles only during a word. It makes exactly one full cycle per bit.
- R2: The serial clock half-period is N+1 system clocks, so its period is 2×(N+1). N is the divider field, control bits [23:16].
- R3: With CPHA (control bit 3) at 0, a bit is placed on the line before the first edge and sampled on leading edges. With CPHA at 1, a bit is placed on leading edges and sampled on trailing edges. In both cases a master looped back on itself receives the word it sent, in all four CPOL/CPHA modes.
- R4: In master mode (control bits 0 and 1 both set) the serial clock and master-out output enables are on and master-in is undriven. In slave mode (bit 0 set, bit 1 clear) only master-in may be driven. The master-out and master-in enables are never on together.
- R5: In slave mode, clock activity while the select input is high changes no state: no receive strobe appears and the next selected word is received correctly.
- R6: A low select input while in master mode aborts any transfer, turns off the serial clock and master-out enables, clears control bit 1 and sets status bit 2. Status bit 2 stays set until stat_clr[1] is pulsed.
- R7: Control bit 5 set to 1 keeps the master-in output enable off in slave mode.
- R8: With control bit 6 set, the slave output is open-drain: a 0 bit drives low with the enable on, and a 1 bit turns the enable off.
- R9: Word length is control bits [9:8] (0: 8, 1: 16, 2 or 3: 32 bits). Control bit 4 selects LSB-first (1) or MSB-first (0). A completed word gives a one-cycle rx_valid with rx_data and sets status bit 1, which stat_clr[0] clears. Status bit 0 is the master busy flag.
- R10: In slave mode with CPHA at 0, the first bit of the slave word appears on master-in once select is low, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 24 | Control register write value |
| ctrl_rdata | output | 24 | Control register contents |
| status | output | 3 | {fault, receive done, busy} |
| stat_clr | input | 2 | Bit 0 clears receive done, bit 1 clears fault |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 32 | Received word |
| sclk_o | output | 1 | Serial clock output |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock input (slave) |
| mosi_o | output | 1 | Master-out data output |
| mosi_oe | output | 1 | Master-out output enable |
| mosi_i | input | 1 | Master-out data input (slave) |
| miso_o | output | 1 | Master-in data output (slave) |
| miso_oe | output | 1 | Master-in output enable |
| miso_i | input | 1 | Master-in data input (master) |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The assertions check the pin rules on every cycle. Master-out and master-in are never enabled together. The slave output stays off when broadcast disable is set and never drives high in open-drain mode. A fault releases the master pins on the next cycle, the fault flag stays set until cleared, and no receive strobe appears while the slave is deselected. Only the bench scenarios can show clock counts, the divider period, bit order on the wire, the data received in each CPOL/CPHA mode, the early first bit in slave mode, and that clock activity while deselected leaves the next word intact.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // Bits per word for the 2-bit length code, capped at the datapath width.
  function automatic int unsigned word_bits(input logic [1:0] len, input int unsigned maxw);
    int unsigned n;
    n = (len == 2'd0) ? 8 : (len == 2'd1) ? 16 : 32;
    return (n > maxw) ? maxw : n;
  endfunction

  // Bit index presented on the data line after e clock edges.
  function automatic int unsigned out_index(input int unsigned e, input logic cpha);
    if (!cpha) return e >> 1;
    return (e == 0) ? 0 : (e - 1) >> 1;
  endfunction

  // Position in the word of the idx-th bit on the wire.
  function automatic int unsigned bit_pos(input int unsigned idx, input int unsigned n,
                                          input logic lsb_first);
    return lsb_first ? idx : (n - 1 - idx);
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST;
      s2 <= RST;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= div;
    else if (cnt == '0)   cnt <= div;
    else                  cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0);

  // R2: counter never exceeds the divider while running with a steady divider
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(div) && $past(run)) |-> (cnt <= div));
endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int CTRL_W = 16 + DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [2:0]        status,
  input  logic [1:0]        stat_clr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  input  logic              ss_n_i
);
  localparam int IW = $clog2(DATA_W);
  localparam int EW = $clog2(2 * DATA_W + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              c_en, c_master, c_cpol, c_cpha, c_lsb, c_sdo_dis, c_od;
  logic [1:0]        c_len;
  logic [DIV_W-1:0]  c_div;

  assign c_en      = ctrl_q[0];
  assign c_master  = ctrl_q[1];
  assign c_cpol    = ctrl_q[2];
  assign c_cpha    = ctrl_q[3];
  assign c_lsb     = ctrl_q[4];
  assign c_sdo_dis = ctrl_q[5];
  assign c_od      = ctrl_q[6];
  assign c_len     = ctrl_q[9:8];
  assign c_div     = ctrl_q[16 +: DIV_W];

  // Pin synchronizers: select resets inactive (high)
  logic ss_q, sclk_q, mosi_q, sclk_d;
  spi_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ss_n_i, sclk_i, mosi_i}),
    .q    ({ss_q, sclk_q, mosi_q})
  );

  logic m_busy, m_tick;
  spi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (m_busy),
    .div  (c_div),
    .tick (m_tick)
  );

  // Named internal events
  logic            is_master, is_slave, s_sel, mm_fault;
  logic            s_edge, edge_evt, smp_evt, word_end, accept;
  logic [EW-1:0]   e_cnt, last_cnt;
  logic [IW-1:0]   smp_pos, out_pos;
  logic            tx_bit, in_bit;
  logic [DATA_W-1:0] tx_word, rx_sr, rx_nxt;
  logic            rx_done_q, err_q;

  assign is_master = c_en && c_master;
  assign is_slave  = c_en && !c_master;
  assign s_sel     = is_slave && !ss_q;
  assign mm_fault  = is_master && !ss_q;
  assign s_edge    = s_sel && (sclk_q ^ sclk_d);
  assign edge_evt  = (is_master && m_busy && m_tick && ss_q) || s_edge;
  assign smp_evt   = edge_evt && (e_cnt[0] == c_cpha);
  assign last_cnt  = EW'(2 * word_bits(c_len, DATA_W) - 1);
  assign word_end  = edge_evt && (e_cnt == last_cnt);
  assign smp_pos   = IW'(bit_pos(32'(e_cnt) >> 1, word_bits(c_len, DATA_W), c_lsb));
  assign out_pos   = IW'(bit_pos(out_index(32'(e_cnt), c_cpha), word_bits(c_len, DATA_W), c_lsb));
  assign tx_bit    = tx_word[out_pos];
  assign in_bit    = is_master ? miso_i : mosi_q;
  assign tx_ready  = is_master ? (!m_busy && ss_q) : (is_slave && (e_cnt == '0));
  assign accept    = tx_valid && tx_ready;

  always_comb begin
    rx_nxt = rx_sr;
    if (smp_evt) rx_nxt[smp_pos] = in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      sclk_d    <= 1'b0;
      m_busy    <= 1'b0;
      e_cnt     <= '0;
      tx_word   <= '0;
      rx_sr     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_done_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      sclk_d   <= sclk_q;
      rx_valid <= word_end;
      if (ctrl_we)  ctrl_q    <= ctrl_wdata;
      if (mm_fault) ctrl_q[1] <= 1'b0;

      if (mm_fault || !is_master)      m_busy <= 1'b0;
      else if (accept)                 m_busy <= 1'b1;
      else if (word_end)               m_busy <= 1'b0;

      if (!(m_busy || s_sel) || word_end || mm_fault) e_cnt <= '0;
      else if (edge_evt)                              e_cnt <= e_cnt + 1'b1;

      if (accept) tx_word <= tx_data;

      if (word_end) begin
        rx_data <= rx_nxt;
        rx_sr   <= '0;
      end else if (!(m_busy || s_sel) || mm_fault) begin
        rx_sr   <= '0;
      end else begin
        rx_sr   <= rx_nxt;
      end

      if (word_end)         rx_done_q <= 1'b1;
      else if (stat_clr[0]) rx_done_q <= 1'b0;
      if (mm_fault)         err_q <= 1'b1;
      else if (stat_clr[1]) err_q <= 1'b0;
    end
  end

  // Pins
  assign sclk_o  = c_cpol ^ (m_busy && e_cnt[0]);
  assign sclk_oe = is_master;
  assign mosi_oe = is_master;
  assign mosi_o  = is_master && tx_bit;
  assign miso_o  = c_od ? 1'b0 : tx_bit;
  assign miso_oe = s_sel && !c_sdo_dis && (!c_od || !tx_bit);

  assign ctrl_rdata = ctrl_q;
  assign status     = {err_q, rx_done_q, m_busy};

  // Assertions
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !m_busy) |-> (sclk_o == c_cpol));
  p_roles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe));
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && ss_q && !$past(s_sel)) |=> !rx_valid);
  p_mm_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_fault && !ctrl_we) |=> (!sclk_oe && !mosi_oe && !status[0]));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !stat_clr[1]) |=> status[2]);
  p_sdo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_sdo_dis |-> !miso_oe);
  p_open_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_od && miso_oe) |-> !miso_o);
  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> status[1]);
endmodule

// File: tb/spi_dual_port_tb_top.sv
module spi_dual_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic [23:0] ctrl_rdata;
  logic [2:0]  status;
  logic [1:0]  stat_clr = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic        sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic        miso_i;

  int errors = 0;
  int checks = 0;
  int rxv_cnt = 0;
  logic [31:0] last_rx = '0;

  always #4 clk = ~clk;

  assign miso_i = mosi_o;  // loopback for master runs

  spi_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .status(status), .stat_clr(stat_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  always @(posedge clk) if (rx_valid) begin
    rxv_cnt <= rxv_cnt + 1;
    last_rx <= rx_data;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb(input int len);
    return (len == 0) ? 8 : (len == 1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] d, input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 1;
    return d & m[31:0];
  endfunction

  function automatic logic wire_bit(input logic [31:0] d, input int n, input int k, input bit lsb);
    return lsb ? d[k] : d[n-1-k];
  endfunction

  task automatic wr_ctrl(input logic [23:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  function automatic logic [23:0] mk(input bit master, input int len, input bit cpol, input bit cpha,
                                     input bit lsb, input bit dis, input bit od, input int div);
    logic [23:0] v;
    v = '0;
    v[0] = 1'b1; v[1] = master; v[2] = cpol; v[3] = cpha; v[4] = lsb;
    v[5] = dis; v[6] = od; v[9:8] = 2'(len); v[23:16] = 8'(div);
    return v;
  endfunction

  task automatic push_tx(input logic [31:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(status == 3'b000, "R9 reset status", 64'(status), 0);
    chk(!sclk_oe && !mosi_oe && !miso_oe, "R4 reset enables", 64'({sclk_oe, mosi_oe, miso_oe}), 0);
  endtask

  task automatic t_master(input int len, input bit cpol, input bit cpha, input bit lsb,
                          input int div, input logic [31:0] d);
    int n = nb(len);
    int leads = 0, cyc = 0, first_lead = -1, second_lead = -1, k = 0, bad = 0;
    logic prev;
    int r0 = rxv_cnt;
    wr_ctrl(mk(1, len, cpol, cpha, lsb, 0, 0, div));
    chk(sclk_oe && mosi_oe && !miso_oe, "R4 master enables", 64'({sclk_oe, mosi_oe, miso_oe}), 64'b110);
    chk(sclk_o == cpol, "R1 idle level", 64'(sclk_o), 64'(cpol));
    push_tx(d);
    prev = sclk_o;
    while (rxv_cnt == r0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sclk_o != prev) begin
        bit lead = (prev == cpol);
        if (lead) begin
          leads++;
          if (first_lead < 0) first_lead = cyc; else if (second_lead < 0) second_lead = cyc;
        end
        if (lead != cpha) begin
          if (k < 32 && mosi_o != wire_bit(d, n, k, lsb)) bad++;
          k++;
        end
        prev = sclk_o;
      end
    end
    @(negedge clk);
    chk(leads == n, "R1 clock cycles per word", 64'(leads), 64'(n));
    chk(sclk_o == cpol, "R1 rest level after word", 64'(sclk_o), 64'(cpol));
    chk(second_lead - first_lead == 2 * (div + 1), "R2 clock period",
        64'(second_lead - first_lead), 64'(2 * (div + 1)));
    chk(bad == 0 && k == n, "R9 bit order on wire", 64'(bad), 0);
    chk(last_rx == msk(d, n), "R3 loopback data", 64'(last_rx), 64'(msk(d, n)));
    chk(status[1] == 1'b1, "R9 receive done flag", 64'(status[1]), 1);
    @(negedge clk); stat_clr = 2'b01; @(negedge clk); stat_clr = 2'b00;
    chk(status[1] == 1'b0, "R9 receive done clear", 64'(status[1]), 0);
  endtask

  task automatic t_slave(input int len, input bit cpol, input bit cpha, input bit lsb,
                         input logic [31:0] md, input logic [31:0] sd, input bit junk);
    int n = nb(len);
    int bad = 0;
    int r0;
    wr_ctrl(mk(0, len, cpol, cpha, lsb, 0, 0, 0));
    sclk_i = cpol;
    push_tx(sd);
    r0 = rxv_cnt;
    if (junk) begin
      for (int j = 0; j < 10; j++) begin
        repeat (3) @(negedge clk);
        sclk_i = ~sclk_i;
        mosi_i = ~mosi_i;
      end
      repeat (3) @(negedge clk);
      sclk_i = cpol;
      repeat (6) @(negedge clk);
      chk(rxv_cnt == r0, "R5 no strobe while deselected", 64'(rxv_cnt - r0), 0);
      chk(!miso_oe, "R5 output off while deselected", 64'(miso_oe), 0);
    end
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(miso_oe && !mosi_oe && !sclk_oe, "R4 slave enables", 64'({sclk_oe, mosi_oe, miso_oe}), 64'b001);
    if (!cpha)
      chk(miso_o == wire_bit(sd, n, 0, lsb), "R10 first bit before clock",
          64'(miso_o), 64'(wire_bit(sd, n, 0, lsb)));
    for (int k = 0; k < n; k++) begin
      if (!cpha) begin
        mosi_i = wire_bit(md, n, k, lsb);
        repeat (8) @(negedge clk);
        sclk_i = ~cpol;
        if (miso_o != wire_bit(sd, n, k, lsb)) bad++;
        repeat (8) @(negedge clk);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol;
        mosi_i = wire_bit(md, n, k, lsb);
        repeat (8) @(negedge clk);
        sclk_i = cpol;
        if (miso_o != wire_bit(sd, n, k, lsb)) bad++;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(bad == 0, "R3 slave bits on wire", 64'(bad), 0);
    chk(rxv_cnt == r0 + 1, "R5 single word strobe", 64'(rxv_cnt - r0), 1);
    chk(last_rx == msk(md, n), "R3 slave receive data", 64'(last_rx), 64'(msk(md, n)));
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_bcast_od;
    wr_ctrl(mk(0, 0, 0, 0, 0, 1, 0, 0));
    push_tx(32'hFF);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(!miso_oe, "R7 output disabled for broadcast", 64'(miso_oe), 0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    wr_ctrl(mk(0, 0, 0, 0, 0, 0, 1, 0));
    push_tx(32'hA5);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(!miso_oe, "R8 open-drain releases a one", 64'(miso_oe), 0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    push_tx(32'h25);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(miso_oe && !miso_o, "R8 open-drain drives a zero low", 64'({miso_oe, miso_o}), 64'b10);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_multimaster;
    wr_ctrl(mk(1, 2, 0, 0, 0, 0, 0, 7));
    push_tx(32'hCAFE_F00D);
    repeat (20) @(negedge clk);
    chk(status[0] == 1'b1, "R6 busy before fault", 64'(status[0]), 1);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(status[2] && !status[0], "R6 fault flag and abort", 64'(status), 64'b100);
    chk(!sclk_oe && !mosi_oe, "R6 master pins released", 64'({sclk_oe, mosi_oe}), 0);
    chk(ctrl_rdata[1] == 1'b0, "R6 master bit cleared", 64'(ctrl_rdata[1]), 0);
    ss_n_i = 1'b1;
    repeat (10) @(negedge clk);
    chk(status[2] == 1'b1, "R6 fault sticky", 64'(status[2]), 1);
    stat_clr = 2'b10; @(negedge clk); stat_clr = 2'b00;
    chk(status[2] == 1'b0, "R6 fault cleared", 64'(status[2]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_master(0, 0, 0, 0, 2, 32'h0000_00A5);
    t_master(1, 1, 1, 1, 0, 32'h0000_1234);
    t_master(2, 0, 1, 0, 1, 32'hDEAD_BEEF);
    t_master(0, 1, 0, 1, 3, 32'h0000_003C);
    t_slave(0, 0, 0, 0, 32'h96, 32'h5A, 1);
    t_slave(1, 1, 1, 1, 32'hBEEF, 32'h1357, 0);
    t_slave(2, 0, 1, 0, 32'h8000_0001, 32'hC3A5_0F96, 1);
    t_slave(0, 1, 0, 1, 32'h6B, 32'hD2, 0);
    t_bcast_od();
    t_multimaster();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule